// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns internal read and write requests into cycles on an external memory bus where the low and high data bytes share pins with address bits. The four lowest address bits have their own lines, although the line for bit 0 changes role with the bus width. Address bits from 4 upward go out on two byte-wide ports during an address phase, marked by a high address latch enable. The same ports then carry data while an active-low read or write strobe is held for a programmable number of wait clocks.

The bus width is set by a strap input, which is sampled once as reset is released. On a 16-bit bus a word moves in a single cycle, and the bit 0 line becomes the high-byte write strobe. On an 8-bit bus a two-byte request is split into two byte cycles, low byte first, and a configuration input sets how many high address bits appear on the high port. The requester holds `req_valid` until `req_done` pulses, then drops it. Read data is valid on `rsp_rdata` from the done pulse onward.

Top module: `xbus_ctrl`

## Requirements
- R1: The bus width is taken from `width_strap` on the first rising clock edge after `rst_n` goes high: 0 gives an 8-bit bus and 1 gives a 16-bit bus. Later changes of the strap have no effect until the next reset.
- R2: Each byte or word cycle is built the same way. There is one clock with `bus_ale` high, then one hold clock with `bus_ale` low and the address still driven, then the strobe is low for `cfg_wait`+1 clocks, then one recovery clock. `req_done` is high for exactly one clock, in the recovery clock of the last cycle. Counted from the clock edge that accepts the request, a request of n cycles ends with `req_done` high after n*(`cfg_wait`+4) edges.
- R3: `bus_a_lo` carries address bits 3:1 for the whole cycle. During the address phase `bus_lo_out` carries address bits 11:4. On a 16-bit bus `bus_hi_out` carries address bits 19:12 with all of `bus_hi_oe` set.
- R4: On an 8-bit bus `bus_a0_wrh` is the byte address bit 0 of the current byte cycle. On a 16-bit bus it is the high-byte write strobe and is low only in the data phase of a write with `req_be[1]`=1.
- R5: Strobes are active low. In any data phase only one class is active: `bus_rd_n` for a read, or the write strobes for a write. On a 16-bit bus `bus_wrl_n` follows `req_be[0]`, the high strobe follows `req_be[1]`, and both are low together for a word write.
- R6: During a read data phase `bus_lo_oe` is 0, and on a 16-bit bus `bus_hi_oe` is all zero. The input bytes are captured on the edge where `bus_rd_n` rises. On a 16-bit bus `rsp_rdata` = {`bus_hi_in`, `bus_lo_in`}.
- R7: On an 8-bit bus, `req_be`=2'b11 runs two byte cycles: first at byte address bit 0 = 0 for data bits 7:0, then at bit 0 = 1 for bits 15:8. Each byte goes over `bus_lo_out`/`bus_lo_in` with `bus_wrl_n` or `bus_rd_n`. `req_be`=2'b01 runs only the low cycle and 2'b10 only the high cycle. Read bytes land in their own lane of `rsp_rdata`, and a lane not read returns 0.
- R8: On an 8-bit bus, `bus_hi_oe[i]` is 1 during the address, hold and data phases for every i < `cfg_hi_cnt`, with `bus_hi_out[i]` = address bit 12+i. All other high pins have `bus_hi_oe` = 0, and with no cycle running all of `bus_hi_oe` is 0.
- R9: `bus_ale` pulses only when a bus cycle runs. A request with `req_be`=2'b00 produces no `bus_ale` pulse and no strobe, and has `req_done` high after the first edge.
- R10: During a write data phase `bus_lo_oe` is 1. On a 16-bit bus `bus_lo_out` carries data bits 7:0 and `bus_hi_out` carries bits 15:8. On an 8-bit bus `bus_lo_out` carries the byte of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| width_strap | input | 1 | Bus width strap, 1 = 16-bit |
| cfg_wait | input | 3 | Data-phase wait clocks (0 to 7), taken at acceptance |
| cfg_hi_cnt | input | 4 | High address bits shown on an 8-bit bus (0 to 8) |
| req_valid | input | 1 | Request present, held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address; bit 0 is not used |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| req_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Assembled read data |
| bus_a_lo | output | 3 | Dedicated address lines for bits 3:1 |
| bus_a0_wrh | output | 1 | Address bit 0 (8-bit) or high write strobe (16-bit) |
| bus_lo_out | output | 8 | Low shared port output |
| bus_lo_oe | output | 1 | Low shared port output enable |
| bus_lo_in | input | 8 | Low shared port input |
| bus_hi_out | output | 8 | High shared port output |
| bus_hi_oe | output | 8 | High shared port per-pin output enable |
| bus_hi_in | input | 8 | High shared port input |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wrl_n | output | 1 | Low-byte write strobe, active low |

## Verification
The hardest case to reach is an 8-bit read of a full word. The second byte cycle must start from the recovery clock rather than from idle, and the two captured bytes must meet in their own lanes before the single done pulse. The bench resets with the strap low and then flips the strap, so that a width change after reset would show up. It runs a word read with a long wait, against a bus model that answers every latched address with a byte computed from that address, and checks both lanes, the two latched addresses and the total clock count. A partial high-port width on an 8-bit bus is covered by a write with `cfg_hi_cnt`=3 to an address with all high bits set, which shows exactly which high pins are driven.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      XB_IDLE  = 3'd0,
      XB_ADDR  = 3'd1,
      XB_HOLD  = 3'd2,
      XB_DATA  = 3'd3,
      XB_RECOV = 3'd4
   } xb_state_e;

   function automatic logic xb_busy(input xb_state_e s);
      return (s == XB_ADDR) || (s == XB_HOLD) || (s == XB_DATA);
   endfunction
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              empty,
   input  logic              split,
   input  logic [WAIT_W-1:0] wait_in,
   output xb_state_e         state,
   output logic              phase,
   output logic              cap_en,
   output logic              done
);
   logic [WAIT_W-1:0] cnt_q;
   logic [WAIT_W-1:0] wait_q;
   logic              split_q;
   logic              skip_q;
   logic              more;

   assign more   = split_q && !phase && !skip_q;
   assign cap_en = (state == XB_DATA) && (cnt_q == wait_q);
   assign done   = (state == XB_RECOV) && !more;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= XB_IDLE;
         cnt_q   <= '0;
         wait_q  <= '0;
         split_q <= 1'b0;
         skip_q  <= 1'b0;
         phase   <= 1'b0;
      end else begin
         unique case (state)
            XB_IDLE: begin
               if (start) begin
                  wait_q  <= wait_in;
                  split_q <= split;
                  skip_q  <= empty;
                  phase   <= 1'b0;
                  state   <= empty ? XB_RECOV : XB_ADDR;
               end
            end
            XB_ADDR: state <= XB_HOLD;
            XB_HOLD: begin
               cnt_q <= '0;
               state <= XB_DATA;
            end
            XB_DATA: begin
               if (cnt_q == wait_q) state <= XB_RECOV;
               else                 cnt_q <= cnt_q + 1'b1;
            end
            XB_RECOV: begin
               if (more) begin
                  phase <= 1'b1;
                  state <= XB_ADDR;
               end else begin
                  state <= XB_IDLE;
               end
            end
            default: state <= XB_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int LANE_W = 8,
   parameter int DED_W  = 4,
   parameter int HCNT_W = 4
) (
   input  xb_state_e           state,
   input  logic                wide,
   input  logic                write,
   input  logic                lane,
   input  logic [1:0]          be,
   input  logic [ADDR_W-1:1]   addr,
   input  logic [2*LANE_W-1:0] wdata,
   input  logic [HCNT_W-1:0]   hi_cnt,
   output logic [DED_W-1:1]    a_lo,
   output logic                a0_wrh,
   output logic [LANE_W-1:0]   lo_out,
   output logic                lo_oe,
   output logic [LANE_W-1:0]   hi_out,
   output logic [LANE_W-1:0]   hi_oe,
   output logic                ale,
   output logic                rd_n,
   output logic                wrl_n
);
   localparam int LO_LSB = DED_W;
   localparam int HI_LSB = DED_W + LANE_W;

   logic apart;
   logic dpart;
   logic busy;
   logic [LANE_W-1:0] lo_addr;
   logic [LANE_W-1:0] hi_addr;
   logic [LANE_W-1:0] lo_wr;

   assign apart   = (state == XB_ADDR) || (state == XB_HOLD);
   assign dpart   = (state == XB_DATA);
   assign busy    = xb_busy(state);
   assign lo_addr = addr[HI_LSB-1:LO_LSB];
   assign hi_addr = addr[ADDR_W-1:HI_LSB];
   assign lo_wr   = (wide || !lane) ? wdata[LANE_W-1:0] : wdata[2*LANE_W-1:LANE_W];

   assign a_lo  = addr[DED_W-1:1];
   assign ale   = (state == XB_ADDR);
   assign rd_n  = !(dpart && !write);
   assign wrl_n = !(dpart && write && (!wide || be[0]));
   assign a0_wrh = wide ? !(dpart && write && be[1]) : lane;

   always_comb begin
      lo_out = lo_addr;
      lo_oe  = 1'b0;
      if (apart) begin
         lo_oe = 1'b1;
      end else if (dpart && write) begin
         lo_out = lo_wr;
         lo_oe  = 1'b1;
      end
   end

   always_comb begin
      hi_out = hi_addr;
      if (wide && dpart && write) hi_out = wdata[2*LANE_W-1:LANE_W];
   end

   for (genvar gi = 0; gi < LANE_W; gi++) begin : g_hi_pin
      logic narrow_en;
      logic wide_en;
      assign narrow_en = busy && (HCNT_W'(gi) < hi_cnt);
      assign wide_en   = apart || (dpart && write);
      assign hi_oe[gi] = wide ? wide_en : narrow_en;
   end
endmodule

// File: rtl/xbus_rdcap.sv
module xbus_rdcap #(
   parameter int LANE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                cap,
   input  logic                wide,
   input  logic                lane,
   input  logic [LANE_W-1:0]   lo_in,
   input  logic [LANE_W-1:0]   hi_in,
   output logic [2*LANE_W-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (clear) begin
         rdata <= '0;
      end else if (cap) begin
         if (wide)      rdata <= {hi_in, lo_in};
         else if (lane) rdata[2*LANE_W-1:LANE_W] <= lo_in;
         else           rdata[LANE_W-1:0] <= lo_in;
      end
   end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int LANE_W = 8,
   parameter int DED_W  = 4,
   parameter int WAIT_W = 3,
   parameter int HCNT_W = $clog2(LANE_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                width_strap,
   input  logic [WAIT_W-1:0]   cfg_wait,
   input  logic [HCNT_W-1:0]   cfg_hi_cnt,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [2*LANE_W-1:0] req_wdata,
   input  logic [1:0]          req_be,
   output logic                req_done,
   output logic [2*LANE_W-1:0] rsp_rdata,
   output logic [DED_W-1:1]    bus_a_lo,
   output logic                bus_a0_wrh,
   output logic [LANE_W-1:0]   bus_lo_out,
   output logic                bus_lo_oe,
   input  logic [LANE_W-1:0]   bus_lo_in,
   output logic [LANE_W-1:0]   bus_hi_out,
   output logic [LANE_W-1:0]   bus_hi_oe,
   input  logic [LANE_W-1:0]   bus_hi_in,
   output logic                bus_ale,
   output logic                bus_rd_n,
   output logic                bus_wrl_n
);
   if (ADDR_W != DED_W + 2 * LANE_W) begin : g_bad_addr
      initial $fatal(1, "xbus_ctrl: ADDR_W must equal DED_W + 2*LANE_W");
   end
   if (DED_W < 2) begin : g_bad_ded
      initial $fatal(1, "xbus_ctrl: DED_W must be at least 2");
   end
   if (WAIT_W < 1) begin : g_bad_wait
      initial $fatal(1, "xbus_ctrl: WAIT_W must be at least 1");
   end

   xb_state_e             state;
   logic                  phase;
   logic                  cap_en;
   logic                  accept;
   logic                  strap_done;
   logic                  wide_q;
   logic                  write_q;
   logic [1:0]            be_q;
   logic [ADDR_W-1:1]     addr_q;
   logic [2*LANE_W-1:0]   wdata_q;
   logic [HCNT_W-1:0]     hicnt_q;
   logic                  lane;
   logic                  unused_a0;

   assign unused_a0 = req_addr[0];
   assign accept    = (state == XB_IDLE) && req_valid && strap_done;
   assign lane      = (!wide_q && be_q == 2'b11) ? phase : be_q[1] && !be_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_done <= 1'b0;
         wide_q     <= 1'b0;
      end else if (!strap_done) begin
         strap_done <= 1'b1;
         wide_q     <= width_strap;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         write_q <= 1'b0;
         be_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         hicnt_q <= '0;
      end else if (accept) begin
         write_q <= req_write;
         be_q    <= req_be;
         addr_q  <= req_addr[ADDR_W-1:1];
         wdata_q <= req_wdata;
         hicnt_q <= cfg_hi_cnt;
      end
   end

   xbus_seq #(.WAIT_W(WAIT_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .empty   (req_be == 2'b00),
      .split   (!wide_q && req_be == 2'b11),
      .wait_in (cfg_wait),
      .state   (state),
      .phase   (phase),
      .cap_en  (cap_en),
      .done    (req_done)
   );

   xbus_pins #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W),
      .DED_W  (DED_W),
      .HCNT_W (HCNT_W)
   ) u_pins (
      .state  (state),
      .wide   (wide_q),
      .write  (write_q),
      .lane   (lane),
      .be     (be_q),
      .addr   (addr_q),
      .wdata  (wdata_q),
      .hi_cnt (hicnt_q),
      .a_lo   (bus_a_lo),
      .a0_wrh (bus_a0_wrh),
      .lo_out (bus_lo_out),
      .lo_oe  (bus_lo_oe),
      .hi_out (bus_hi_out),
      .hi_oe  (bus_hi_oe),
      .ale    (bus_ale),
      .rd_n   (bus_rd_n),
      .wrl_n  (bus_wrl_n)
   );

   xbus_rdcap #(.LANE_W(LANE_W)) u_rdcap (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .cap   (cap_en && !write_q),
      .wide  (wide_q),
      .lane  (lane),
      .lo_in (bus_lo_in),
      .hi_in (bus_hi_in),
      .rdata (rsp_rdata)
   );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
   parameter int LANE_W = 8,
   parameter int DED_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_done,
   input logic              wide_q,
   input logic              req_valid,
   input logic              req_done,
   input logic [DED_W-1:1]  bus_a_lo,
   input logic              bus_a0_wrh,
   input logic              bus_lo_oe,
   input logic [LANE_W-1:0] bus_hi_oe,
   input logic              bus_ale,
   input logic              bus_rd_n,
   input logic              bus_wrl_n
);
   logic wrh_act;
   logic [LANE_W-1:0] hi_oe_p1;
   assign wrh_act  = wide_q && !bus_a0_wrh;
   assign hi_oe_p1 = bus_hi_oe + 1'b1;

   p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      strap_done |=> $stable(wide_q));

   p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |=> !bus_ale);

   p_ale_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> (bus_rd_n && bus_wrl_n && !wrh_act));

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);

   p_alo_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n && $past(!bus_rd_n)) |-> $stable(bus_a_lo));

   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> (bus_wrl_n && !wrh_act));

   p_rd_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> (!bus_lo_oe && (!wide_q || bus_hi_oe == '0)));

   p_hi_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_q |-> ((bus_hi_oe & hi_oe_p1) == '0));

   p_ale_on_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ale) |-> $past(req_valid));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.LANE_W(LANE_W), .DED_W(DED_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .strap_done (strap_done),
   .wide_q     (wide_q),
   .req_valid  (req_valid),
   .req_done   (req_done),
   .bus_a_lo   (bus_a_lo),
   .bus_a0_wrh (bus_a0_wrh),
   .bus_lo_oe  (bus_lo_oe),
   .bus_hi_oe  (bus_hi_oe),
   .bus_ale    (bus_ale),
   .bus_rd_n   (bus_rd_n),
   .bus_wrl_n  (bus_wrl_n)
);

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        width_strap = 1'b0;
   logic [2:0]  cfg_wait = '0;
   logic [3:0]  cfg_hi_cnt = 4'd8;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_done;
   logic [15:0] rsp_rdata;
   logic [3:1]  bus_a_lo;
   logic        bus_a0_wrh;
   logic [7:0]  bus_lo_out;
   logic        bus_lo_oe;
   logic [7:0]  bus_lo_in;
   logic [7:0]  bus_hi_out;
   logic [7:0]  bus_hi_oe;
   logic [7:0]  bus_hi_in;
   logic        bus_ale;
   logic        bus_rd_n;
   logic        bus_wrl_n;

   int errors = 0;
   int checks = 0;
   bit finished = 0;
   bit wide_b = 0;

   // bus model state
   logic [19:0] lat_addr = '0;
   int          n_ale;
   logic [19:0] log_addr [4];
   logic [7:0]  log_hoe  [4];
   logic [2:0]  log_kind [4];
   logic [7:0]  log_lo   [4];
   logic [7:0]  log_hi   [4];
   logic        log_oe   [4];
   int          log_len  [4];
   int          latency;
   logic [15:0] got_rdata;

   always #4 clk = ~clk;

   function automatic logic [7:0] mem_byte(input logic [19:0] a);
      return a[11:4] ^ {a[3:0], a[3:0]} ^ 8'h3C;
   endfunction

   assign bus_lo_in = mem_byte(lat_addr);
   assign bus_hi_in = mem_byte(lat_addr | 20'h1);

   xbus_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .width_strap(width_strap),
      .cfg_wait(cfg_wait), .cfg_hi_cnt(cfg_hi_cnt),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .req_done(req_done),
      .rsp_rdata(rsp_rdata), .bus_a_lo(bus_a_lo), .bus_a0_wrh(bus_a0_wrh),
      .bus_lo_out(bus_lo_out), .bus_lo_oe(bus_lo_oe), .bus_lo_in(bus_lo_in),
      .bus_hi_out(bus_hi_out), .bus_hi_oe(bus_hi_oe), .bus_hi_in(bus_hi_in),
      .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wrl_n(bus_wrl_n)
   );

   // passive monitor, samples away from the active edge
   always @(negedge clk) begin
      logic wrh;
      wrh = wide_b && !bus_a0_wrh;
      if (rst_n && bus_ale && n_ale < 4) begin
         lat_addr = {bus_hi_out & bus_hi_oe, bus_lo_out, bus_a_lo, wide_b ? 1'b0 : bus_a0_wrh};
         log_addr[n_ale] = lat_addr;
         log_hoe[n_ale]  = bus_hi_oe;
         log_len[n_ale]  = 0;
         log_kind[n_ale] = 3'b000;
         n_ale++;
      end
      if (rst_n && n_ale > 0 && (!bus_rd_n || !bus_wrl_n || wrh)) begin
         log_kind[n_ale-1] = {!bus_rd_n, !bus_wrl_n, wrh};
         log_lo[n_ale-1]   = bus_lo_out;
         log_hi[n_ale-1]   = bus_hi_out;
         log_oe[n_ale-1]   = bus_lo_oe;
         log_len[n_ale-1]  = log_len[n_ale-1] + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      rst_n = 1'b0;
      width_strap = strap;
      wide_b = strap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      width_strap = !strap;
   endtask

   task automatic run(input logic wr, input logic [19:0] a, input logic [15:0] d,
                      input logic [1:0] be, input logic [2:0] w, input logic [3:0] hc);
      int k;
      @(negedge clk);
      n_ale = 0;
      for (int i = 0; i < 4; i++) log_len[i] = 0;
      req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      cfg_wait = w; cfg_hi_cnt = hc; req_valid = 1'b1;
      k = 0;
      while (k < 200) begin
         @(negedge clk);
         k++;
         if (req_done) break;
      end
      latency = k;
      got_rdata = rsp_rdata;
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R2 reset ale", bus_ale, 0);
      check("R5 reset strobes", {bus_rd_n, bus_wrl_n}, 2'b11);
      check("R8 reset hi_oe", bus_hi_oe, 0);
      check("R6 reset lo_oe", bus_lo_oe, 0);
      check("R2 reset done", req_done, 0);
   endtask

   task automatic t_wide_word_write;
      run(1, 20'hABCD6, 16'h1357, 2'b11, 3'd2, 4'd8);
      check("R1 wide strap one cycle", n_ale, 1);
      check("R2 latency w=2", latency, 6);
      check("R3 wide address", log_addr[0], 20'hABCD6);
      check("R3 wide hi_oe in addr phase", log_hoe[0], 8'hFF);
      check("R5 word write strobes", log_kind[0], 3'b011);
      check("R10 wide write data", {log_hi[0], log_lo[0]}, 16'h1357);
      check("R2 strobe length w=2", log_len[0], 3);
   endtask

   task automatic t_wide_high_write;
      run(1, 20'h12344, 16'hBEEF, 2'b10, 3'd1, 4'd8);
      check("R4 only high strobe", log_kind[0], 3'b001);
      check("R10 wide high data", log_hi[0], 8'hBE);
      check("R2 latency w=1", latency, 5);
   endtask

   task automatic t_wide_read;
      run(0, 20'h5A5A2, 16'h0, 2'b11, 3'd0, 4'd8);
      check("R5 read strobe only", log_kind[0], 3'b100);
      check("R6 lo port released", log_oe[0], 0);
      check("R6 wide read data", got_rdata, {mem_byte(20'h5A5A3), mem_byte(20'h5A5A2)});
      check("R2 latency w=0", latency, 4);
   endtask

   task automatic t_empty;
      run(1, 20'h11110, 16'hFFFF, 2'b00, 3'd3, 4'd8);
      check("R9 no ale for empty", n_ale, 0);
      check("R9 empty latency", latency, 1);
      check("R9 no strobe", log_len[0], 0);
   endtask

   task automatic t_narrow_write;
      run(1, 20'h3C0F0, 16'hA1B2, 2'b11, 3'd1, 4'd8);
      check("R7 two byte cycles", n_ale, 2);
      check("R7 first addr", log_addr[0], 20'h3C0F0);
      check("R4 second addr bit0", log_addr[1], 20'h3C0F1);
      check("R10 first byte", log_lo[0], 8'hB2);
      check("R10 second byte", log_lo[1], 8'hA1);
      check("R7 low strobe used", {log_kind[0], log_kind[1]}, 6'b010_010);
      check("R2 split latency", latency, 10);
   endtask

   task automatic t_narrow_read;
      run(0, 20'h00246, 16'h0, 2'b11, 3'd3, 4'd8);
      check("R7 read two cycles", n_ale, 2);
      check("R7 assembled read", got_rdata, {mem_byte(20'h00247), mem_byte(20'h00246)});
      check("R2 split read latency", latency, 14);
      check("R2 strobe length w=3", log_len[1], 4);
   endtask

   task automatic t_narrow_hi_lane_read;
      run(0, 20'h00C88, 16'h0, 2'b10, 3'd0, 4'd8);
      check("R7 single cycle", n_ale, 1);
      check("R4 high lane addr", log_addr[0], 20'h00C89);
      check("R7 lane data, other zero", got_rdata, {mem_byte(20'h00C89), 8'h00});
   endtask

   task automatic t_narrow_partial_hi;
      run(1, 20'hFFFF0, 16'h0055, 2'b01, 3'd7, 4'd3);
      check("R8 hi_oe mask", log_hoe[0], 8'h07);
      check("R8 masked address", log_addr[0], 20'h07FF0);
      check("R2 strobe length w=7", log_len[0], 8);
      check("R2 latency w=7", latency, 11);
      check("R8 idle hi_oe", bus_hi_oe, 8'h00);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      n_ale = 0;
      t_reset_state();
      do_reset(1'b1);
      t_wide_word_write();
      t_wide_high_write();
      t_wide_read();
      t_empty();
      do_reset(1'b0);
      t_narrow_write();
      t_narrow_read();
      t_narrow_hi_lane_read();
      t_narrow_partial_hi();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule